// File: doc/BRIEF.md
# Completion-Checked Capture Monitor

This block sits beside a dual-rail combinational stage that reports when all of its outputs have settled. A one-cycle strobe from the clock generator marks each capturing edge. At an accepted strobe the monitor drives the stage back to its spacer (all-rails-low) state for a programmable number of fast-clock cycles. It then watches the stage's completion line, after two synchronizing flops, to decide whether the next capture took settled data. A capture that comes before completion is reported as late. The late report raises a sticky flag and bumps a saturating counter, which can be used for speed binning.

In live-run mode, a late capture also raises a stretch request. The clock generator treats the next strobe as an extra evaluation cycle rather than a real capture. The stage is given no spacer in that cycle, and completion is checked again at the strobe after it. Separately, the monitor requires the completion line to be low when the spacer pulse ends. A strobe that arrives while the spacer pulse is still running is treated as a spacer fault.

The controller has four states:
- IDLE: out of reset, waiting for the first strobe.
- SPACER: the stage reset is high.
- EVAL: the stage is computing.
- HOLD: the stage is computing and a stretch is requested.

Its transitions are:
- start: IDLE to SPACER on a strobe.
- pulse_end: SPACER to EVAL when the width is reached.
- restart: SPACER to SPACER on a strobe.
- capture_ok: EVAL or HOLD to SPACER on a strobe with completion seen.
- capture_late: EVAL or HOLD to SPACER on a late strobe when not live.
- stretch: EVAL or HOLD to HOLD on a late strobe when live.

Top module: `cdm_completion_monitor`

## Requirements
- R1: While reset is asserted and until the first strobe, stage_rst, late_err, spacer_err and stretch_req are 0 and late_cnt is 0.
- R2: An accepted strobe at edge k drives stage_rst high in the cycles after edges k through k+W-1, where W is rst_width (0 counts as 1). rst_width is latched at the strobe, and changes to it during the pulse do not alter the pulse length.
- R3: The completion input passes through two flops. At a capture strobe on edge T, completion counts as reached only if cmp_in was 1 at edge T-2.
- R4: A capture strobe in EVAL or HOLD with completion not reached sets late_err and adds 1 to late_cnt, both visible after that edge.
- R5: late_cnt stops at 2^CW-1, which is 15 for the default width of 4; further late captures leave it at 15.
- R6: err_clr clears late_err, spacer_err and late_cnt at the next edge. Without it, both flags stay set. A new event in the same cycle as a clear wins over the clear.
- R7: On the edge where the spacer pulse ends, if the synchronized completion (cmp_in at that edge minus 2) is 1, spacer_err is set.
- R8: A strobe that arrives while stage_rst is still high sets spacer_err and restarts the pulse with the newly latched width. No late check is made on that strobe.
- R9: With live_mode 1 at a late capture, no spacer pulse follows. stretch_req is 1 from the next cycle until the next strobe, and that strobe checks completion again.
- R10: With live_mode 0, a late capture is followed by a normal spacer pulse, and stretch_req stays 0.
- R11: The first strobe after reset starts a spacer pulse and makes no completion check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock |
| rst_n | input | 1 | synchronous active-low reset |
| cap_tick | input | 1 | one-cycle strobe marking a capturing edge |
| cmp_in | input | 1 | completion line from the stage (asynchronous) |
| live_mode | input | 1 | 1 selects stretch on late capture |
| err_clr | input | 1 | clears flags and counter |
| rst_width | input | WW | spacer pulse length in cycles |
| stage_rst | output | 1 | spacer drive to the stage |
| late_err | output | 1 | sticky late-capture flag |
| spacer_err | output | 1 | sticky spacer fault flag |
| stretch_req | output | 1 | skip the next capture |
| late_cnt | output | CW | saturating late-capture count |

## Verification
The bench sweeps every rise offset of completion against every spacer width, in both modes.

Some corner cases are easy to get wrong. An off-by-one in the synchronizer depth would flag a capture as late, or as good, exactly at the offset two cycles before the strobe. A width of 0 or 1 with completion still high from the previous cycle must raise the spacer fault. A design that ignored the fault would start evaluating on stale completion.

Strobes that arrive before the pulse ends check restart and fault reporting. Long runs of late captures check that the counter holds at its maximum rather than wrapping to zero. In live mode, a design that issued a spacer during the stretch cycle would show a pulse the bench counts as nonzero.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPACER = 2'd1,
        ST_EVAL   = 2'd2,
        ST_HOLD   = 2'd3
    } cdm_state_e;
endpackage

// File: rtl/cdm_sync2.sv
module cdm_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    localparam int TOP = STAGES - 1;
    logic [TOP:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("cdm_sync2 needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], d_in};
    end

    assign q_out = chain_q[TOP];

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (chain_q[1] == $past(chain_q[0])));
endmodule

// File: rtl/cdm_spacer_timer.sv
module cdm_spacer_timer #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [WW-1:0] width,
    output logic          done
);
    localparam logic [WW-1:0] ONE = {{(WW-1){1'b0}}, 1'b1};

    logic [WW-1:0] cnt_q;
    logic [WW-1:0] lim_q;
    logic [WW-1:0] eff_w;

    assign eff_w = (width == '0) ? ONE : width;
    assign done  = (cnt_q >= lim_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ONE;
            lim_q <= ONE;
        end else if (load) begin
            cnt_q <= ONE;
            lim_q <= eff_w;
        end else if (run && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    limit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (lim_q == $past(lim_q)));
endmodule

// File: rtl/cdm_sat_counter.sv
module cdm_sat_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clr)                   cnt_q <= inc ? ONE : '0;
        else if (inc && cnt_q != MAXV)  cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && !clr) |=> (cnt_q == MAXV));
endmodule

// File: rtl/cdm_completion_monitor.sv
module cdm_completion_monitor
    import cdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WW          = 4,
    parameter int CW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_tick,
    input  logic          cmp_in,
    input  logic          live_mode,
    input  logic          err_clr,
    input  logic [WW-1:0] rst_width,
    output logic          stage_rst,
    output logic          late_err,
    output logic          spacer_err,
    output logic          stretch_req,
    output logic [CW-1:0] late_cnt
);
    cdm_state_e state_q, state_d;
    logic       cmp_s;
    logic       tmr_done;
    logic       tmr_load;
    logic       late_evt;
    logic       sp_evt;
    logic       late_q, sp_q;

    cdm_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(cmp_in), .q_out(cmp_s)
    );

    cdm_spacer_timer #(.WW(WW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .run(state_q == ST_SPACER), .width(rst_width), .done(tmr_done)
    );

    cdm_sat_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(late_evt), .clr(err_clr), .count(late_cnt)
    );

    // next state and event strobes
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        late_evt = 1'b0;
        sp_evt   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cap_tick) begin
                    state_d  = ST_SPACER;
                    tmr_load = 1'b1;
                end
            end
            ST_SPACER: begin
                if (cap_tick) begin
                    sp_evt   = 1'b1;
                    tmr_load = 1'b1;
                end else if (tmr_done) begin
                    state_d = ST_EVAL;
                    sp_evt  = cmp_s;
                end
            end
            ST_EVAL, ST_HOLD: begin
                if (cap_tick) begin
                    if (!cmp_s) begin
                        late_evt = 1'b1;
                        if (live_mode) begin
                            state_d = ST_HOLD;
                        end else begin
                            state_d  = ST_SPACER;
                            tmr_load = 1'b1;
                        end
                    end else begin
                        state_d  = ST_SPACER;
                        tmr_load = 1'b1;
                    end
                end else if (state_q == ST_HOLD) begin
                    state_d = ST_HOLD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_q <= 1'b0;
            sp_q   <= 1'b0;
        end else begin
            if (late_evt)     late_q <= 1'b1;
            else if (err_clr) late_q <= 1'b0;
            if (sp_evt)       sp_q   <= 1'b1;
            else if (err_clr) sp_q   <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        stage_rst   = (state_q == ST_SPACER);
        stretch_req = (state_q == ST_HOLD);
        late_err    = late_q;
        spacer_err  = sp_q;
    end

    // R2
    spacer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_rst) |-> $past(cap_tick));

    // R6
    late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (late_err && !err_clr) |=> late_err);

    // R6
    spacer_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spacer_err && !err_clr) |=> spacer_err);

    // R9
    stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch_req) |-> (late_err && $past(live_mode)));

    // R4
    count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (late_cnt >= $past(late_cnt)));
endmodule

// File: tb/cdm_completion_monitor_tb.sv
module cdm_completion_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_tick = 1'b0;
    logic       cmp_in = 1'b0;
    logic       live_mode = 1'b0;
    logic       err_clr = 1'b0;
    logic [3:0] rst_width = 4'd0;
    logic       stage_rst, late_err, spacer_err, stretch_req;
    logic [3:0] late_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit exp_late = 0;
    bit exp_sp = 0;
    int phase = 0;      // 0 idle, 1 evaluating, 2 evaluating with stretch, 3 pulse interrupted
    bit cmp_m2 = 0;

    always #10 clk = ~clk;

    cdm_completion_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .cap_tick(cap_tick), .cmp_in(cmp_in),
        .live_mode(live_mode), .err_clr(err_clr), .rst_width(rst_width),
        .stage_rst(stage_rst), .late_err(late_err), .spacer_err(spacer_err),
        .stretch_req(stretch_req), .late_cnt(late_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one capture period of 'per' cycles; completion rises at offset d (d >= per: never)
    task automatic run_cycle(input int w, input int d, input int per, input bit clr_end);
        bit skip = 0;
        bit sp_val;
        int weff = (w == 0) ? 1 : w;
        int j = weff - 2;
        int hi = 0;
        sp_val = cmp_in;
        case (phase)
            1, 2: if (!cmp_m2) begin                       // R3, R4
                if (exp_cnt < 15) exp_cnt++;              // R5
                exp_late = 1;
                if (live_mode) skip = 1;                  // R9
            end
            3: exp_sp = 1;                                // R8
            default: ;                                    // R11
        endcase
        @(negedge clk);
        cap_tick = 1'b1;
        err_clr = 1'b0;
        rst_width = 4'(w);
        for (int i = 1; i < per; i++) begin
            @(negedge clk);
            cap_tick = 1'b0;
            if (i == 1) begin
                rst_width = ~4'(w);                       // R2 latched width
                if (!skip) cmp_in = 1'b0;
                chk("R9/R10 stretch_req", int'(stretch_req), int'(skip));
                chk("R4 late_err", int'(late_err), int'(exp_late));
                chk("R4/R5 late_cnt", int'(late_cnt), exp_cnt);
                chk("R7/R8 spacer_err", int'(spacer_err), int'(exp_sp));
            end
            if (i == d) cmp_in = 1'b1;
            if (stage_rst) hi++;
            if (i == j) sp_val = cmp_in;
            if (i == per - 2) cmp_m2 = cmp_in;
            if (i == per - 1 && clr_end) err_clr = 1'b1;  // R6
        end
        chk("R2 pulse length", hi, skip ? 0 : ((weff < per - 1) ? weff : per - 1));
        if (skip) phase = 2;
        else if (per <= weff) phase = 3;
        else begin
            phase = 1;
            if (sp_val) exp_sp = 1;                       // R7
        end
        if (clr_end) begin
            exp_cnt = 0; exp_late = 0; exp_sp = 0;
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1
        chk("R1 stage_rst", int'(stage_rst), 0);
        chk("R1 late_err", int'(late_err), 0);
        chk("R1 spacer_err", int'(spacer_err), 0);
        chk("R1 stretch_req", int'(stretch_req), 0);
        chk("R1 late_cnt", int'(late_cnt), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle stage_rst", int'(stage_rst), 0);

        // R10 sweep: not live
        live_mode = 1'b0;
        for (int w = 0; w <= 5; w++)
            for (int d = 1; d <= 8; d++)
                run_cycle(w, d, 8, d == 8);
        // R5 saturation
        for (int k = 0; k < 20; k++) run_cycle(3, 9, 8, 1'b0);
        run_cycle(3, 2, 8, 1'b1);
        // R9 sweep: live
        live_mode = 1'b1;
        for (int w = 1; w <= 5; w++)
            for (int d = 1; d <= 8; d++)
                run_cycle(w, d, 8, d == 8);
        for (int k = 0; k < 4; k++) run_cycle(4, 9, 8, 1'b0);
        run_cycle(4, 3, 8, 1'b0);
        run_cycle(4, 3, 8, 1'b1);
        // R8 early strobes
        live_mode = 1'b0;
        for (int p = 3; p <= 6; p++) begin
            run_cycle(5, 9, p, 1'b0);
            run_cycle(5, 7, 8, 1'b0);
            run_cycle(3, 4, 8, 1'b1);
        end
        run_cycle(2, 4, 8, 1'b0);
        @(negedge clk);
        err_clr = 1'b0;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule